// File: doc/BRIEF.md
# QPSK Sample Input Conditioner

This block sits between an external dual-channel converter and the demodulator's filter and recovery chain. Each master clock it may accept a pair of 6-bit in-phase and quadrature samples. It turns them into signed two's-complement values, whatever coding the converter uses. It can also negate the quadrature stream, so a modulator that rotates the other way can be handled without swapping the input wires. The master clock runs at twice the symbol rate, so two samples make up each symbol. The block tags every output sample with the half of the symbol it belongs to.

A small configuration register, written through a simple address/data strobe, holds three control bits. These are the input coding, the Q negation and a pass-through flag that the downstream filter reads to decide whether to bypass itself. The block also runs a free divider. It gives a square wave at one sixtieth of the master clock, which other parts of the system use.

Top module: `qpsk_sample_cond`

## Requirements
- R1: After synchronous reset the configuration equals binary 100 (bit 0 offset coding = 0, bit 1 Q negate = 0, bit 2 pass-through = 1), `bypass_o` is 1, `out_valid` is 0, `i_out` and `q_out` are 0 and `div60_o` is 0.
- R2: With configuration bit 0 clear, each input sample is taken as two's complement and appears unchanged on the output.
- R3: With configuration bit 0 set, each input is taken as an unsigned offset value and the output equals the raw value minus 32 (most significant bit inverted).
- R4: With configuration bit 1 set, `q_out` is the arithmetic negative of the converted Q sample, and `i_out` is unaffected.
- R5: Negating the converted Q value -32 gives +31 (saturation), never -32.
- R6: A sample presented with `in_valid` high appears on the outputs with `out_valid` high exactly one clock later. Without `in_valid`, `out_valid` is low and the output data holds its last value.
- R7: `sym_phase` is 0 on the first valid output after reset and alternates on every later valid output.
- R8: `div60_o` stays low for the first 30 clocks after reset, then alternates 30 clocks high and 30 clocks low (period 60).
- R9: A configuration write takes effect only when `cfg_addr` is 0. A write to any other address leaves the configuration, including `bypass_o`, unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, twice the symbol rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 3 | Configuration data: bit0 offset coding, bit1 Q negate, bit2 pass-through |
| in_valid | input | 1 | Input sample pair valid |
| i_raw | input | 6 | Raw in-phase sample from converter |
| q_raw | input | 6 | Raw quadrature sample from converter |
| out_valid | output | 1 | Output sample pair valid |
| i_out | output | 6 | Signed in-phase sample |
| q_out | output | 6 | Signed, optionally negated quadrature sample |
| sym_phase | output | 1 | Which half of the symbol the output sample belongs to |
| bypass_o | output | 1 | Filter pass-through flag from configuration |
| div60_o | output | 1 | Master clock divided by 60, 50% duty |

## Verification
The hardest case to reach is saturation on negation. It needs the offset coding and the Q negate bits in the right combination, with a raw word that maps to -32: raw 0 in offset mode, or raw 100000 in two's-complement mode. The stimulus writes each combination and then sends exactly those edge codes, next to ordinary values on either side. The symbol phase and the divider both depend on the number of cycles since reset, so those scenarios apply a fresh reset first and count cycles from its release.

// File: rtl/qsc_pkg.sv
package qsc_pkg;

    localparam int SAMPLE_W = 6;
    localparam int CFG_W    = 3;
    localparam int ADDR_W   = 4;
    localparam int CLK_DIV  = 60;

    localparam logic [ADDR_W-1:0] CFG_ADDR = '0;

    typedef struct packed {
        logic pass_thru;   // bit 2
        logic neg_q;       // bit 1
        logic offs_code;   // bit 0
    } cfg_t;

    localparam cfg_t CFG_RESET = '{pass_thru: 1'b1, neg_q: 1'b0, offs_code: 1'b0};

endpackage

// File: rtl/qsc_cfg_reg.sv
module qsc_cfg_reg
    import qsc_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t          cfg
);

    logic hit;

    assign hit = wr && (addr == AW'(CFG_ADDR));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (hit) begin
            cfg <= cfg_t'(wdata);
        end
    end

endmodule

// File: rtl/qsc_chan.sv
module qsc_chan #(
    parameter int W      = 6,
    parameter bit NEG_EN = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         offs_code,
    input  logic         neg,
    input  logic [W-1:0] raw,
    output logic [W-1:0] dout
);

    localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0] signed_v;
    logic [W-1:0] final_v;

    // offset coding: raw - 2^(W-1) is the raw word with its MSB flipped
    assign signed_v = offs_code ? (raw ^ MSB_MASK) : raw;

    generate
        if (NEG_EN) begin : g_neg
            logic [W-1:0] negated;
            always_comb begin
                if (signed_v == MOST_NEG) begin
                    negated = MOST_POS;
                end else begin
                    negated = (~signed_v) + W'(1);
                end
            end
            assign final_v = neg ? negated : signed_v;
        end else begin : g_plain
            logic unused_neg;
            assign unused_neg = neg;
            assign final_v    = signed_v;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (load) begin
            dout <= final_v;
        end
    end

endmodule

// File: rtl/qsc_clkdiv.sv
module qsc_clkdiv #(
    parameter int DIV = 60
) (
    input  logic clk,
    input  logic rst,
    output logic div_o
);

    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            div_o <= 1'b0;
        end else if (cnt == CW'(HALF - 1)) begin
            cnt   <= '0;
            div_o <= ~div_o;
        end else begin
            cnt   <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/qpsk_sample_cond.sv
module qpsk_sample_cond
    import qsc_pkg::*;
#(
    parameter int W   = SAMPLE_W,
    parameter int AW  = ADDR_W,
    parameter int DIV = CLK_DIV
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             in_valid,
    input  logic [W-1:0]     i_raw,
    input  logic [W-1:0]     q_raw,
    output logic             out_valid,
    output logic [W-1:0]     i_out,
    output logic [W-1:0]     q_out,
    output logic             sym_phase,
    output logic             bypass_o,
    output logic             div60_o
);

    cfg_t cfg_q;
    logic neg_q_w;
    logic phase_q;

    qsc_cfg_reg #(.AW(AW)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    assign neg_q_w  = cfg_q.neg_q;
    assign bypass_o = cfg_q.pass_thru;

    qsc_chan #(.W(W), .NEG_EN(1'b0)) u_chan_i (
        .clk       (clk),
        .rst       (rst),
        .load      (in_valid),
        .offs_code (cfg_q.offs_code),
        .neg       (1'b0),
        .raw       (i_raw),
        .dout      (i_out)
    );

    qsc_chan #(.W(W), .NEG_EN(1'b1)) u_chan_q (
        .clk       (clk),
        .rst       (rst),
        .load      (in_valid),
        .offs_code (cfg_q.offs_code),
        .neg       (neg_q_w),
        .raw       (q_raw),
        .dout      (q_out)
    );

    qsc_clkdiv #(.DIV(DIV)) u_div (
        .clk   (clk),
        .rst   (rst),
        .div_o (div60_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            sym_phase <= 1'b0;
            phase_q   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sym_phase <= phase_q;
                phase_q   <= ~phase_q;
            end
        end
    end

endmodule

// File: rtl/qpsk_sample_cond_chk.sv
module qpsk_sample_cond_chk #(
    parameter int W   = 6,
    parameter int DIV = 60
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         out_valid,
    input logic [W-1:0] q_out,
    input logic         sym_phase,
    input logic         neg_q,
    input logic         div60_o
);

    localparam int HALF = DIV / 2;
    localparam int RW   = $clog2(DIV + 1);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic          prev_div;
    logic [RW-1:0] run;
    logic          seen;
    logic          last_ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_div <= 1'b0;
            run      <= '0;
            seen     <= 1'b0;
            last_ph  <= 1'b0;
        end else begin
            prev_div <= div60_o;
            if (div60_o != prev_div) begin
                run <= RW'(1);
            end else if (run != RW'(DIV)) begin
                run <= run + RW'(1);
            end
            if (out_valid) begin
                seen    <= 1'b1;
                last_ph <= sym_phase;
            end
        end
    end

    // R6
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R6
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R5
    neg_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && neg_q) |=> (q_out != MOST_NEG));

    // R7
    phase_alt_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && seen) |-> (sym_phase != last_ph));

    // R8
    div_half_chk: assert property (@(posedge clk) disable iff (rst)
        (div60_o != prev_div) |-> (run == RW'(HALF)));

    // R1
    reset_valid_chk: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

bind qpsk_sample_cond qpsk_sample_cond_chk #(.W(W), .DIV(DIV)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .q_out     (q_out),
    .sym_phase (sym_phase),
    .neg_q     (neg_q_w),
    .div60_o   (div60_o)
);

// File: tb/qpsk_sample_cond_tb_top.sv
module qpsk_sample_cond_tb_top;

    localparam int W = 6;

    logic         clk = 1'b0;
    logic         rst;
    logic         cfg_wr;
    logic [3:0]   cfg_addr;
    logic [2:0]   cfg_wdata;
    logic         in_valid;
    logic [W-1:0] i_raw, q_raw;
    logic         out_valid;
    logic [W-1:0] i_out, q_out;
    logic         sym_phase, bypass_o, div60_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    qpsk_sample_cond dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .i_raw(i_raw),
        .q_raw(q_raw), .out_valid(out_valid), .i_out(i_out), .q_out(q_out),
        .sym_phase(sym_phase), .bypass_o(bypass_o), .div60_o(div60_o)
    );

    task automatic check(string req, int actual, int expected);
        tests++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    function automatic int sval(logic [W-1:0] v);
        return $signed(v);
    endfunction

    function automatic int conv(logic [W-1:0] raw, bit offs);
        return offs ? sval(raw) >= 0 ? int'(raw) - 32 : int'(raw) - 32 + 64 - 64 : sval(raw);
    endfunction

    function automatic int expect_q(logic [W-1:0] raw, bit offs, bit neg);
        int v;
        v = offs ? int'(raw) - 32 : sval(raw);
        if (neg) v = (v == -32) ? 31 : -v;
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        in_valid = 1'b0; i_raw = '0; q_raw = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_cfg(logic [3:0] a, logic [2:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic send(logic [W-1:0] iv, logic [W-1:0] qv);
        @(negedge clk);
        in_valid = 1'b1; i_raw = iv; q_raw = qv;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 out_valid", out_valid, 0);
        check("R1 i_out", i_out, 0);
        check("R1 q_out", q_out, 0);
        check("R1 bypass_o", bypass_o, 1);
        check("R1 div60_o", div60_o, 0);
    endtask

    task automatic t_divider();
        int bad = 0;
        do_reset();
        for (int k = 1; k <= 150; k++) begin
            @(negedge clk);
            if (div60_o != ((k / 30) % 2)) bad++;
        end
        check("R8 div60 mismatching cycles", bad, 0);
    endtask

    task automatic t_twos();
        logic [W-1:0] vals [4] = '{6'h20, 6'h1F, 6'h00, 6'h3F};
        write_cfg(4'h0, 3'b000);
        foreach (vals[n]) begin
            send(vals[n], vals[3-n]);
            check("R2 i_out", sval(i_out), sval(vals[n]));
            check("R2 q_out", sval(q_out), sval(vals[3-n]));
        end
    endtask

    task automatic t_offset();
        logic [W-1:0] vals [4] = '{6'd0, 6'd63, 6'd32, 6'd17};
        write_cfg(4'h0, 3'b001);
        foreach (vals[n]) begin
            send(vals[n], vals[n]);
            check("R3 i_out", sval(i_out), int'(vals[n]) - 32);
            check("R3 q_out", sval(q_out), int'(vals[n]) - 32);
        end
    endtask

    task automatic t_negate();
        write_cfg(4'h0, 3'b010);
        send(6'd5, 6'd5);
        check("R4 q negated", sval(q_out), -5);
        check("R4 i untouched", sval(i_out), 5);
        send(6'h1F, 6'h1F);
        check("R4 q 31", sval(q_out), -31);
        send(6'h20, 6'h20);
        check("R5 q -32 saturates", sval(q_out), 31);
        check("R4 i -32 kept", sval(i_out), -32);
        write_cfg(4'h0, 3'b011);
        send(6'd0, 6'd0);
        check("R5 offset raw 0 negated", sval(q_out), expect_q(6'd0, 1'b1, 1'b1));
        send(6'd40, 6'd40);
        check("R4 offset negate", sval(q_out), expect_q(6'd40, 1'b1, 1'b1));
        check("R4 offset i", sval(i_out), 8);
    endtask

    task automatic t_latency();
        write_cfg(4'h0, 3'b000);
        @(negedge clk);
        in_valid = 1'b1; i_raw = 6'd9; q_raw = 6'd12;
        check("R6 not yet valid", out_valid, 0);
        @(negedge clk);
        in_valid = 1'b0; i_raw = 6'd1; q_raw = 6'd2;
        check("R6 valid after one clock", out_valid, 1);
        check("R6 i data", sval(i_out), 9);
        @(negedge clk);
        check("R6 valid drops", out_valid, 0);
        check("R6 i holds", sval(i_out), 9);
        check("R6 q holds", sval(q_out), 12);
    endtask

    task automatic t_phase();
        do_reset();
        for (int n = 0; n < 5; n++) begin
            send(6'(n), 6'(n));
            check("R7 sym_phase", sym_phase, n % 2);
        end
    endtask

    task automatic t_addr();
        write_cfg(4'h0, 3'b100);
        write_cfg(4'h3, 3'b011);
        check("R9 bypass kept on other address", bypass_o, 1);
        send(6'h20, 6'h05);
        check("R9 coding unchanged", sval(i_out), -32);
        check("R9 negate unchanged", sval(q_out), 5);
        write_cfg(4'h0, 3'b000);
        check("R9 bypass cleared", bypass_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_divider();
        t_twos();
        t_offset();
        t_negate();
        t_latency();
        t_phase();
        t_addr();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule